// File: doc/BRIEF.md
# UART Interrupt Cause and Status Collector

This block is the status and interrupt section of a UART. It collects five kinds of cause: receive line errors, receive data available, character timeout, transmit space available and modem input changes. It keeps them as a bitmap of pending cause bits, so that several causes can be pending at once. A single interrupt line is raised while any pending cause is also enabled. Software reads one 32-bit status word and services every set cause. It then writes the handled cause bits back into the low status byte, and that write clears them.

The block also keeps the modem status byte and the line status byte. The modem status byte holds synchronized modem input levels and sticky change flags. The line status byte holds sticky receive error flags and live data and transmitter levels. The status word also carries the receive FIFO fill count. A configuration write loads the four interrupt enables and the six modem control outputs. The FIFOs and the serial engine are outside this block and drive its inputs.

Top module: `uirq_status_unit`

## Requirements
- R1: After reset, the status cause field, all modem change flags, all sticky error flags, the interrupt output, the enables and the modem control outputs are 0.
- R2: Status bits [4:0] form a pending bitmap with these positions: bit 0 line error, bit 1 receive data available, bit 2 character timeout, bit 3 transmit space, bit 4 modem change. Any combination of these bits can be set together.
- R3: Configuration bits [3:0] are enables. Bit 0 gates cause bits 1 and 2, bit 1 gates cause bit 3, bit 2 gates cause bit 0, and bit 3 gates cause bit 4. A cause sets its pending bit one clock edge after its condition is seen with its enable at 1. It never sets the bit while its enable is 0.
- R4: A status byte write clears, at the next edge, every pending bit whose bit in write data [4:0] is 1. Pending bits written with 0 are kept, and write data bits [7:5] have no effect. If the condition of a cleared cause is still active, its bit sets again one edge later.
- R5: irq_o is 1 exactly when some pending bit is 1 and its enable is also 1.
- R6: Status bits [11:8] are change flags for modem inputs CTS, DSR, RI and DCD (modem_i bits 0 to 3), in that order. Each input passes through two synchronizer flops, and any edge of the synchronized value sets its flag. The flags clear when cause bit 4 is cleared; an edge in the same cycle wins over the clear. Any flag set is the condition for cause bit 4.
- R7: Status bits [15:12] show the synchronized levels of CTS, DSR, RI and DCD, in that order.
- R8: Status bits [23:16] are the line status byte. Bit 16 is 1 when the receive count is nonzero. Bits 17 to 20 are sticky overrun, parity, framing and break flags, set from rx_err_i bits 0 to 3. Bits 21 and 22 show tx_hold_empty_i and tx_idle_i. Bit 23 is a sticky receive FIFO error flag, set from rx_err_i bit 4.
- R9: Status bits [31:24] carry rx_count_i[7:0] and bits [7:6] carry rx_count_i[9:8]. Bit 5 reads 0. Status byte writes do not change these bits.
- R10: Configuration bits [29:24] drive mctl_o[5:0] in this order: DTR, RTS, OUT1, OUT2, loopback, automatic flow control. They hold until the next configuration write.
- R11: A one-cycle rx_tmo_i pulse is held until cause bit 2 is cleared. A pulse in the same cycle as the clear wins. The held flag is the condition for cause bit 2.
- R12: The condition for cause bit 0 is any sticky line error flag set. Those flags clear when cause bit 0 is cleared; an error in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| stat_wr_i | input | 1 | Status low-byte write strobe (write-back clear) |
| stat_wdata_i | input | 8 | Status low-byte write data |
| rx_err_i | input | 5 | Error event pulses: overrun, parity, framing, break, FIFO error |
| rx_tmo_i | input | 1 | Character timeout pulse |
| rx_avail_i | input | 1 | Receive level reached |
| rx_count_i | input | 10 | Receive FIFO fill count |
| tx_space_i | input | 1 | Transmit space available level |
| tx_hold_empty_i | input | 1 | Transmit holding empty level |
| tx_idle_i | input | 1 | Transmitter fully empty level |
| modem_i | input | 4 | Asynchronous CTS, DSR, RI, DCD inputs |
| status_o | output | 32 | Packed status word |
| irq_o | output | 1 | Interrupt request |
| mctl_o | output | 6 | Modem control outputs |

## Verification
The bench targets several corner cases. The first is a write-back clear while a level cause such as receive data available is still active. A design that lets the set win would never show the one-cycle dip, and a design that forgets the condition would lose the cause. The second is an error pulse, timeout pulse or modem edge that lands in the same cycle as its clear; a wrong priority there silently drops an event. Random status writes also carry bits [7:5], which must change neither causes nor the live count bits. Random enable changes show whether a disabled cause leaks into the pending field or into the interrupt line.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int unsigned ID_W    = 5;
    localparam int unsigned EN_W    = 4;
    localparam int unsigned MDM_W   = 4;
    localparam int unsigned ERR_W   = 5;
    localparam int unsigned CNT_W   = 10;
    localparam int unsigned MCTL_W  = 6;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned SYNC_N  = 2;

    // cause bit positions in the status word
    localparam int unsigned ID_LINE    = 0;
    localparam int unsigned ID_RXDATA  = 1;
    localparam int unsigned ID_TIMEOUT = 2;
    localparam int unsigned ID_TXSPACE = 3;
    localparam int unsigned ID_MODEM   = 4;

    // enable bit positions in the configuration word
    localparam int unsigned EN_RX    = 0;
    localparam int unsigned EN_TX    = 1;
    localparam int unsigned EN_LINE  = 2;
    localparam int unsigned EN_MODEM = 3;

    localparam int unsigned MCTL_LSB = 24;

    // error input bit positions
    localparam int unsigned ERR_OVR  = 0;
    localparam int unsigned ERR_PAR  = 1;
    localparam int unsigned ERR_FRM  = 2;
    localparam int unsigned ERR_BRK  = 3;
    localparam int unsigned ERR_FIFO = 4;

    typedef struct packed {
        logic [EN_W-1:0]   en;
        logic [MCTL_W-1:0] mctl;
    } cfg_t;

endpackage

// File: rtl/uirq_modem_sync.sv
module uirq_modem_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] delta_o
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
        logic [WIDTH-1:0]             prev;
        logic [WIDTH-1:0]             delta;
    } msync_t;

    msync_t st_d, st_q;
    logic [WIDTH-1:0] edge_w;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
        edge_w     = st_q.pipe[STAGES-1] ^ st_q.prev;
        st_d.prev  = st_q.pipe[STAGES-1];
        // a fresh edge wins over a clear in the same cycle
        st_d.delta = clr_i ? edge_w : (st_q.delta | edge_w);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.pipe[STAGES-1];
    assign delta_o = st_q.delta;

    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
        p_delta_from_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(st_q.delta[i]) |-> $past(edge_w[i]));
        p_delta_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i && !edge_w[i]) |=> !st_q.delta[i]);
    end

endmodule

// File: rtl/uirq_line_latch.sv
module uirq_line_latch #(
    parameter int unsigned WIDTH = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] event_i,
    input  logic             tmo_i,
    input  logic             clr_err_i,
    input  logic             clr_tmo_i,
    output logic [WIDTH-1:0] err_o,
    output logic             tmo_o
);

    typedef struct packed {
        logic [WIDTH-1:0] err;
        logic             tmo;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // new events win over the clear so that none is lost
        st_d.err = clr_err_i ? event_i : (st_q.err | event_i);
        st_d.tmo = clr_tmo_i ? tmo_i   : (st_q.tmo | tmo_i);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_o = st_q.err;
    assign tmo_o = st_q.tmo;

    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
        p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!clr_err_i && st_q.err[i]) |=> st_q.err[i]);
    end

    p_tmo_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_tmo_i && st_q.tmo) |=> st_q.tmo);

endmodule

// File: rtl/uirq_cause_reg.sv
module uirq_cause_reg #(
    parameter int unsigned WIDTH = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] cond_i,
    input  logic [WIDTH-1:0] en_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] pend_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [WIDTH-1:0] pend;
    } cause_t;

    cause_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < WIDTH; i++) begin
            // clear drops the bit for one edge; an active cause returns next edge
            if (clr_i[i]) begin
                st_d.pend[i] = 1'b0;
            end else if (cond_i[i] && en_i[i]) begin
                st_d.pend[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign irq_o  = |(st_q.pend & en_i);

    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
        p_rise_needs_enable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(st_q.pend[i]) |-> $past(en_i[i] && cond_i[i]));
        p_clear_takes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            clr_i[i] |=> !st_q.pend[i]);
    end

    p_irq_needs_pending_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (st_q.pend != '0));

endmodule

// File: rtl/uirq_status_unit.sv
module uirq_status_unit
    import uirq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_wr_i,
    input  logic [WORD_W-1:0] cfg_wdata_i,
    input  logic              stat_wr_i,
    input  logic [7:0]        stat_wdata_i,
    input  logic [ERR_W-1:0]  rx_err_i,
    input  logic              rx_tmo_i,
    input  logic              rx_avail_i,
    input  logic [CNT_W-1:0]  rx_count_i,
    input  logic              tx_space_i,
    input  logic              tx_hold_empty_i,
    input  logic              tx_idle_i,
    input  logic [MDM_W-1:0]  modem_i,
    output logic [WORD_W-1:0] status_o,
    output logic              irq_o,
    output logic [MCTL_W-1:0] mctl_o
);

    cfg_t cfg_d, cfg_q;

    logic [ID_W-1:0]  clr_vec;
    logic [ID_W-1:0]  en_vec;
    logic [ID_W-1:0]  cond_vec;
    logic [ID_W-1:0]  pend_w;
    logic [ERR_W-1:0] err_w;
    logic             tmo_w;
    logic [MDM_W-1:0] mlevel_w;
    logic [MDM_W-1:0] mdelta_w;
    logic [7:0]       lsr_w;
    logic [7:0]       msr_w;
    logic             unused_bits;

    assign unused_bits = ^{stat_wdata_i[7:ID_W], cfg_wdata_i[WORD_W-1:MCTL_LSB+MCTL_W],
                           cfg_wdata_i[MCTL_LSB-1:EN_W]};

    // configuration register
    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr_i) begin
            cfg_d.en   = cfg_wdata_i[EN_W-1:0];
            cfg_d.mctl = cfg_wdata_i[MCTL_LSB +: MCTL_W];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // cause routing
    always_comb begin
        clr_vec = stat_wr_i ? stat_wdata_i[ID_W-1:0] : '0;

        en_vec             = '0;
        en_vec[ID_LINE]    = cfg_q.en[EN_LINE];
        en_vec[ID_RXDATA]  = cfg_q.en[EN_RX];
        en_vec[ID_TIMEOUT] = cfg_q.en[EN_RX];
        en_vec[ID_TXSPACE] = cfg_q.en[EN_TX];
        en_vec[ID_MODEM]   = cfg_q.en[EN_MODEM];

        cond_vec             = '0;
        cond_vec[ID_LINE]    = |err_w;
        cond_vec[ID_RXDATA]  = rx_avail_i;
        cond_vec[ID_TIMEOUT] = tmo_w;
        cond_vec[ID_TXSPACE] = tx_space_i;
        cond_vec[ID_MODEM]   = |mdelta_w;
    end

    uirq_line_latch #(.WIDTH(ERR_W)) u_line (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .event_i   (rx_err_i),
        .tmo_i     (rx_tmo_i),
        .clr_err_i (clr_vec[ID_LINE]),
        .clr_tmo_i (clr_vec[ID_TIMEOUT]),
        .err_o     (err_w),
        .tmo_o     (tmo_w)
    );

    uirq_modem_sync #(.WIDTH(MDM_W), .STAGES(SYNC_N)) u_modem (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (modem_i),
        .clr_i   (clr_vec[ID_MODEM]),
        .level_o (mlevel_w),
        .delta_o (mdelta_w)
    );

    uirq_cause_reg #(.WIDTH(ID_W)) u_cause (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .cond_i (cond_vec),
        .en_i   (en_vec),
        .clr_i  (clr_vec),
        .pend_o (pend_w),
        .irq_o  (irq_o)
    );

    // status word packing
    always_comb begin
        lsr_w    = '0;
        lsr_w[0] = (rx_count_i != '0);
        lsr_w[1] = err_w[ERR_OVR];
        lsr_w[2] = err_w[ERR_PAR];
        lsr_w[3] = err_w[ERR_FRM];
        lsr_w[4] = err_w[ERR_BRK];
        lsr_w[5] = tx_hold_empty_i;
        lsr_w[6] = tx_idle_i;
        lsr_w[7] = err_w[ERR_FIFO];

        msr_w = {mlevel_w, mdelta_w};

        status_o          = '0;
        status_o[ID_W-1:0] = pend_w;
        status_o[7:6]     = rx_count_i[CNT_W-1:8];
        status_o[15:8]    = msr_w;
        status_o[23:16]   = lsr_w;
        status_o[31:24]   = rx_count_i[7:0];
    end

    assign mctl_o = cfg_q.mctl;

    p_mctl_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_wr_i |=> $stable(mctl_o));

    p_no_irq_without_enable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_q.en == '0) |-> !irq_o);

endmodule

// File: tb/uirq_status_unit_tb.sv
module uirq_status_unit_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni;
    logic        cfg_wr_i;
    logic [31:0] cfg_wdata_i;
    logic        stat_wr_i;
    logic [7:0]  stat_wdata_i;
    logic [4:0]  rx_err_i;
    logic        rx_tmo_i;
    logic        rx_avail_i;
    logic [9:0]  rx_count_i;
    logic        tx_space_i;
    logic        tx_hold_empty_i;
    logic        tx_idle_i;
    logic [3:0]  modem_i;
    logic [31:0] status_o;
    logic        irq_o;
    logic [5:0]  mctl_o;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk_i = ~clk_i;

    uirq_status_unit dut_i (
        .clk_i (clk_i), .rst_ni (rst_ni),
        .cfg_wr_i (cfg_wr_i), .cfg_wdata_i (cfg_wdata_i),
        .stat_wr_i (stat_wr_i), .stat_wdata_i (stat_wdata_i),
        .rx_err_i (rx_err_i), .rx_tmo_i (rx_tmo_i), .rx_avail_i (rx_avail_i),
        .rx_count_i (rx_count_i), .tx_space_i (tx_space_i),
        .tx_hold_empty_i (tx_hold_empty_i), .tx_idle_i (tx_idle_i),
        .modem_i (modem_i), .status_o (status_o), .irq_o (irq_o), .mctl_o (mctl_o)
    );

    // reference state built from the requirements
    logic [3:0] m_en;
    logic [5:0] m_mctl;
    logic [4:0] m_err;
    logic       m_tmo;
    logic [3:0] m_s1, m_s2, m_prev, m_delta;
    logic [4:0] m_id;

    always @(posedge clk_i) begin : ref_model
        logic [4:0] clr, cond, env;
        logic [3:0] edg;
        if (!rst_ni) begin
            m_en <= '0; m_mctl <= '0; m_err <= '0; m_tmo <= 1'b0;
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_delta <= '0; m_id <= '0;
        end else begin
            clr  = stat_wr_i ? stat_wdata_i[4:0] : 5'd0;
            env  = {m_en[3], m_en[1], m_en[0], m_en[0], m_en[2]};
            cond = {|m_delta, tx_space_i, m_tmo, rx_avail_i, |m_err};
            edg  = m_s2 ^ m_prev;
            m_id    <= ~clr & (m_id | (cond & env));
            m_err   <= clr[0] ? rx_err_i : (m_err | rx_err_i);
            m_tmo   <= clr[2] ? rx_tmo_i : (m_tmo | rx_tmo_i);
            m_delta <= clr[4] ? edg : (m_delta | edg);
            m_prev  <= m_s2;
            m_s2    <= m_s1;
            m_s1    <= modem_i;
            if (cfg_wr_i) begin
                m_en   <= cfg_wdata_i[3:0];
                m_mctl <= cfg_wdata_i[29:24];
            end
        end
    end

    function automatic logic [7:0] exp_lsr(input logic [4:0] e, input logic [9:0] c,
                                           input logic he, input logic ie);
        return {e[4], ie, he, e[3], e[2], e[1], e[0], (c != 10'd0)};
    endfunction

    function automatic logic exp_irq(input logic [4:0] id, input logic [3:0] en);
        return |(id & {en[3], en[1], en[0], en[0], en[2]});
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // one cycle: sample at the falling edge and compare every field
    task automatic step();
        @(negedge clk_i);
        chk("R2/R3/R4 cause field", {27'd0, status_o[4:0]}, {27'd0, m_id});
        chk("R6 change flags", {28'd0, status_o[11:8]}, {28'd0, m_delta});
        chk("R7 modem levels", {28'd0, status_o[15:12]}, {28'd0, m_s2});
        chk("R8/R12 line byte", {24'd0, status_o[23:16]},
            {24'd0, exp_lsr(m_err, rx_count_i, tx_hold_empty_i, tx_idle_i)});
        chk("R9 count bits", {status_o[31:24], 16'd0, status_o[7:5], 5'd0},
            {rx_count_i[7:0], 16'd0, rx_count_i[9:8], 1'b0, 5'd0});
        chk("R5 irq", {31'd0, irq_o}, {31'd0, exp_irq(m_id, m_en)});
        chk("R10 modem control", {26'd0, mctl_o}, {26'd0, m_mctl});
    endtask

    task automatic idle_inputs();
        cfg_wr_i = 0; cfg_wdata_i = '0; stat_wr_i = 0; stat_wdata_i = '0;
        rx_err_i = '0; rx_tmo_i = 0; rx_avail_i = 0; rx_count_i = '0;
        tx_space_i = 0; tx_hold_empty_i = 0; tx_idle_i = 0; modem_i = '0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk_i);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h1A2B3C4D));
        idle_inputs();
        rst_ni = 0;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1;

        // R1: reset state
        step();
        chk("R1 status after reset", status_o, 32'd0);
        chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
        chk("R1 mctl after reset", {26'd0, mctl_o}, 32'd0);

        // R3: a disabled cause never becomes pending
        rx_avail_i = 1;
        repeat (3) step();
        chk("R3 disabled cause stays clear", {31'd0, status_o[1]}, 32'd0);

        // enable all, set modem controls
        cfg_wr_i = 1; cfg_wdata_i = 32'h2F00_000F;
        step();
        cfg_wr_i = 0;
        step();
        chk("R5 irq with enabled cause", {31'd0, irq_o}, 32'd1);
        chk("R10 modem control value", {26'd0, mctl_o}, 32'h2F);

        // R2: several causes at once
        rx_err_i = 5'b00001; rx_tmo_i = 1; tx_space_i = 1; rx_count_i = 10'h3C5;
        step();
        rx_err_i = '0; rx_tmo_i = 0;
        step(); step();
        chk("R2 multiple causes pending", {27'd0, status_o[4:0]}, 32'h0F);
        chk("R8 overrun flag", {31'd0, status_o[17]}, 32'd1);

        // R4: clear all with upper write bits set; level causes return
        stat_wr_i = 1; stat_wdata_i = 8'hFF;
        step();
        stat_wr_i = 0;
        chk("R4 clear drops all", {27'd0, status_o[4:0]}, 32'd0);
        chk("R12 errors cleared with cause 0", {31'd0, status_o[17]}, 32'd0);
        chk("R9 count unaffected by write", {24'd0, status_o[31:24]}, 32'hC5);
        chk("R9 count high bits", {30'd0, status_o[7:6]}, 32'd3);
        step();
        chk("R4 level causes re-assert", {27'd0, status_o[4:0]}, 32'h0A);
        chk("R11 timeout stays cleared", {31'd0, status_o[2]}, 32'd0);

        // R6/R7: modem edges through the synchronizer
        modem_i = 4'b0101;
        repeat (4) step();
        chk("R6/R7 modem byte", {24'd0, status_o[15:8]}, 32'h55);
        chk("R6 modem cause", {31'd0, status_o[4]}, 32'd1);
        stat_wr_i = 1; stat_wdata_i = 8'h10;
        step();
        stat_wr_i = 0;
        chk("R6 flags cleared", {28'd0, status_o[11:8]}, 32'd0);
        chk("R7 levels kept", {28'd0, status_o[15:12]}, 32'd5);

        // random phase
        for (int cyc = 0; cyc < 4000; cyc++) begin
            rx_err_i   = (($urandom % 12) == 0) ? 5'($urandom) : 5'd0;
            rx_tmo_i   = (($urandom % 20) == 0);
            if (($urandom % 8) == 0) rx_avail_i = ~rx_avail_i;
            if (($urandom % 9) == 0) tx_space_i = ~tx_space_i;
            tx_hold_empty_i = 1'($urandom);
            tx_idle_i  = 1'($urandom);
            rx_count_i = 10'($urandom);
            if (($urandom % 7) == 0) modem_i = modem_i ^ 4'($urandom);
            stat_wr_i  = (($urandom % 5) == 0);
            stat_wdata_i = 8'($urandom);
            cfg_wr_i   = (($urandom % 40) == 0);
            cfg_wdata_i = $urandom;
            step();
        end
        idle_inputs();
        step();

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule